// File: doc/BRIEF.md
# Paired-Hit Meantimer and Multiplicity Encoder

This block sits behind sixteen discriminated hit lines from eight scintillator bars, each bar read at both ends. It brings every line into the 40 MHz clock domain and widens each hit by one extra clock cycle. Bar ends can be up to 17 ns apart, and one cycle is 25 ns, so the two widened signals of a real bar hit overlap. It then ANDs the two ends of each bar into one coincidence bit.

A counting window opens on the first new coincidence and lasts a programmed number of cycles. The block counts coincidence rising edges inside that window. It then reports the total to the next trigger stage as one pulse whose length in cycles equals the count. Coincidences that arrive while a pulse is being sent are kept and open the next window. A window length of zero turns counting and reporting off.

Top module: `pair_meantimer`

## Requirements
- R1: While reset is high, and on the first cycle after it, the coincidence vector is all zero and the pulse output is low.
- R2: Bar b is formed from channels 2b and 2b+1. A bar coincides only when both of its ends are hit in the same cycle or in adjacent cycles. Ends two or more cycles apart give no coincidence and no pulse.
- R3: When both ends of a bar are high for one cycle and are sampled at edge k, coincidence bit b is high after edges k+3 and k+4 and low after edge k+5.
- R4: Each rising edge of a bar's coincidence counts once. A hit level held for many cycles counts as 1, and two separate hits on the same bar inside one window count as 2.
- R5: A window opens on the clock edge that registers the first new coincidence, and covers that edge plus the next L-1 edges, where L is the window length input.
- R6: At the end of a window with count N>0, the pulse output is high for exactly N consecutive cycles. For hits sampled at edge k, it first rises after edge k+L+5. A zero count gives no pulse.
- R7: The count saturates at the number of bars (8), so no pulse is ever longer than 8 cycles.
- R8: Coincidences that occur while a pulse is being sent are held. They open a new window right after that pulse ends, which leads to a second pulse of their own length.
- R9: While the window length is zero, no pulse is produced and all pending counts are discarded. After a nonzero length is restored, only new hits are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 16 | Discriminated hit lines; bar b uses bits 2b and 2b+1 |
| win_len | input | 8 | Counting window length in cycles; 0 disables |
| coinc | output | 8 | Registered per-bar coincidence vector |
| width_pulse | output | 1 | Multiplicity pulse, high for N cycles for count N |

## Verification
The bench tests end skew at one and two cycles. A design that stretches too much would accept the two-cycle case, and one that does not stretch would drop the one-cycle case. A hit held high for several cycles must count once, and repeated hits on one bar must count separately. Level counting would give a long pulse for the held hit, and OR-based counting would give 1 for the repeats. The bench also covers ten hits in a long window, which a design without saturation would report as a 10-cycle pulse or wrap to a short one. It sends hits during an active pulse, which would be lost if they were not held, and it clears the window length mid-stream, which would leak stale counts if the held state were not cleared.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_EMIT  = 2'd2
  } pme_state_e;
endpackage

// File: rtl/pme_hit_sync.sv
module pme_hit_sync #(
  parameter int CHANNELS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] async_in,
  output logic [CHANNELS-1:0] sync_out
);
  logic [CHANNELS-1:0] meta_q;
  logic [CHANNELS-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/pme_bar_pair.sv
module pme_bar_pair #(
  parameter int NUM_BARS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_BARS-1:0] ends_in,
  output logic [NUM_BARS-1:0]   coinc_out
);
  localparam int CH = 2 * NUM_BARS;

  logic [CH-1:0]       prev_q;
  logic [CH-1:0]       wide_q;
  logic [NUM_BARS-1:0] coinc_q;

  // one extra cycle of width per end: wide = now | last cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      wide_q <= '0;
    end else begin
      prev_q <= ends_in;
      wide_q <= ends_in | prev_q;
    end
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    always_ff @(posedge clk) begin
      if (rst) coinc_q[b] <= 1'b0;
      else     coinc_q[b] <= wide_q[2*b] & wide_q[2*b+1];
    end
  end

  assign coinc_out = coinc_q;
endmodule

// File: rtl/pme_window_enc.sv
module pme_window_enc
  import pme_pkg::*;
#(
  parameter int NUM_BARS = 8,
  parameter int WIN_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BARS-1:0] coinc,
  input  logic [WIN_W-1:0]    win_len,
  output logic                width_pulse
);
  localparam int SUM_W = $clog2(2*NUM_BARS+1);
  localparam int CNT_W = $clog2(NUM_BARS+1);
  localparam logic [SUM_W-1:0] CAP = SUM_W'(NUM_BARS);

  pme_state_e          state_q;
  logic [NUM_BARS-1:0] prev_q;
  logic [NUM_BARS-1:0] rise;
  logic [SUM_W-1:0]    pop;
  logic [SUM_W-1:0]    cnt_sum;
  logic [SUM_W-1:0]    held_sum;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    held_q;
  logic [CNT_W-1:0]    remain_q;
  logic [WIN_W-1:0]    timer_q;
  logic                pulse_q;

  function automatic logic [CNT_W-1:0] clip(input logic [SUM_W-1:0] v);
    clip = (v > CAP) ? CNT_W'(NUM_BARS) : v[CNT_W-1:0];
  endfunction

  assign rise = coinc & ~prev_q;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NUM_BARS; i++) pop = pop + SUM_W'(rise[i]);
  end

  assign cnt_sum  = SUM_W'(cnt_q) + pop;
  assign held_sum = SUM_W'(held_q) + pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      prev_q   <= '0;
      cnt_q    <= '0;
      held_q   <= '0;
      remain_q <= '0;
      timer_q  <= '0;
      pulse_q  <= 1'b0;
    end else begin
      prev_q <= coinc;
      if (win_len == '0) begin
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        held_q   <= '0;
        remain_q <= '0;
        timer_q  <= '0;
        pulse_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            pulse_q <= 1'b0;
            if (held_sum != '0) begin
              state_q <= ST_COUNT;
              cnt_q   <= clip(held_sum);
              held_q  <= '0;
              timer_q <= WIN_W'(1);
            end
          end
          ST_COUNT: begin
            pulse_q <= 1'b0;
            if (timer_q >= win_len) begin
              state_q  <= ST_EMIT;
              remain_q <= cnt_q;
              held_q   <= clip(held_sum);
            end else begin
              cnt_q   <= clip(cnt_sum);
              timer_q <= timer_q + 1'b1;
            end
          end
          ST_EMIT: begin
            held_q <= clip(held_sum);
            if (remain_q != '0) begin
              pulse_q  <= 1'b1;
              remain_q <= remain_q - 1'b1;
            end else begin
              pulse_q <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          default: begin
            state_q <= ST_IDLE;
            pulse_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign width_pulse = pulse_q;
endmodule

// File: rtl/pair_meantimer.sv
module pair_meantimer #(
  parameter int NUM_BARS = 8,
  parameter int WIN_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_BARS-1:0] hit_in,
  input  logic [WIN_W-1:0]      win_len,
  output logic [NUM_BARS-1:0]   coinc,
  output logic                  width_pulse
);
  localparam int CHANNELS = 2 * NUM_BARS;

  logic [CHANNELS-1:0] hit_sync;

  pme_hit_sync #(.CHANNELS(CHANNELS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (hit_in),
    .sync_out (hit_sync)
  );

  pme_bar_pair #(.NUM_BARS(NUM_BARS)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .ends_in   (hit_sync),
    .coinc_out (coinc)
  );

  pme_window_enc #(.NUM_BARS(NUM_BARS), .WIN_W(WIN_W)) u_enc (
    .clk         (clk),
    .rst         (rst),
    .coinc       (coinc),
    .win_len     (win_len),
    .width_pulse (width_pulse)
  );
endmodule

// File: rtl/pme_chk.sv
module pme_chk #(
  parameter int NUM_BARS = 8,
  parameter int WIN_W    = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*NUM_BARS-1:0] hit_in,
  input logic [WIN_W-1:0]      win_len,
  input logic [NUM_BARS-1:0]   coinc,
  input logic                  width_pulse
);
  localparam int RUN_W = $clog2(NUM_BARS+2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !width_pulse) run_q <= '0;
    else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (coinc == '0 && !width_pulse));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(NUM_BARS));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(win_len) == '0) |-> !width_pulse);

  // R2
  for (genvar b = 0; b < NUM_BARS; b++) begin : g_src
    pair_src_chk: assert property (@(posedge clk) disable iff (rst)
      coinc[b] |-> (($past(hit_in[2*b], 4) || $past(hit_in[2*b], 5)) &&
                    ($past(hit_in[2*b+1], 4) || $past(hit_in[2*b+1], 5))));
  end
endmodule

bind pair_meantimer pme_chk #(.NUM_BARS(NUM_BARS), .WIN_W(WIN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hit_in      (hit_in),
  .win_len     (win_len),
  .coinc       (coinc),
  .width_pulse (width_pulse)
);

// File: tb/pair_meantimer_test.sv
`timescale 1ns/1ps
module pair_meantimer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] hit = '0;
  logic [7:0]  win_len = 8'd4;
  logic [7:0]  coinc;
  logic        width_pulse;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pair_meantimer uut (
    .clk(clk), .rst(rst), .hit_in(hit), .win_len(win_len),
    .coinc(coinc), .width_pulse(width_pulse)
  );

  // pattern, window length
  localparam logic [23:0] VEC [6] = '{
    {16'hFFFF, 8'd4}, {16'h0003, 8'd3}, {16'h5555, 8'd4},
    {16'h000F, 8'd1}, {16'hC30C, 8'd6}, {16'h00FF, 8'd10}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bars_hit(input logic [15:0] p);
    int n = 0;
    for (int b = 0; b < 8; b++) if (p[2*b] && p[2*b+1]) n++;
    return n;
  endfunction

  // drive pattern for one cycle; returns at the sample point after edge k
  task automatic fire(input logic [15:0] p);
    @(negedge clk); hit = p;
    @(negedge clk); hit = '0;
  endtask

  task automatic observe(input int n, output int first, output int w1,
                         output int w2, output int np, output bit cseen);
    first = -1; w1 = 0; w2 = 0; np = 0; cseen = 0;
    for (int i = 0; i < n; i++) begin
      if (coinc != '0) cseen = 1;
      if (width_pulse) begin
        if (first < 0) first = i;
        if (np == 0 || (np == 1 && w2 == 0 && i > 0 && w1 > 0 && !prev_high)) np++;
        if (np == 1) w1++; else w2++;
      end
      prev_high = width_pulse;
      @(negedge clk);
    end
  endtask
  bit prev_high = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first, w1, w2, np, exp;
    bit cs;
    repeat (4) @(negedge clk);
    check(coinc == '0, "R1 coinc in reset", coinc, 0);
    check(!width_pulse, "R1 pulse in reset", width_pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check(coinc == '0 && !width_pulse, "R1 after reset", {coinc, width_pulse}, 0);
    repeat (4) @(negedge clk);

    // vector table: R5 R6 latency and width
    foreach (VEC[v]) begin
      win_len = VEC[v][7:0];
      exp = bars_hit(VEC[v][23:8]);
      prev_high = 0;
      fire(VEC[v][23:8]);
      observe(int'(win_len) + 25, first, w1, w2, np, cs);
      check(w1 == exp, "R6 pulse width", w1, exp);
      if (exp > 0) check(first == int'(win_len) + 5, "R5 R6 pulse start", first, int'(win_len) + 5);
      else check(np == 0, "R6 zero count no pulse", np, 0);
    end

    // R3 coincidence timing
    win_len = 8'd4;
    fire(16'h0003);
    for (int i = 0; i < 7; i++) begin
      exp = (i == 3 || i == 4) ? 1 : 0;
      check(coinc[0] == exp[0], "R3 coinc timing", coinc[0], exp);
      @(negedge clk);
    end
    repeat (20) @(negedge clk);

    // R2 skew of one cycle accepted
    win_len = 8'd4;
    @(negedge clk); hit = 16'h0001;
    @(negedge clk); hit = 16'h0002;
    @(negedge clk); hit = '0;
    prev_high = 0;
    observe(30, first, w1, w2, np, cs);
    check(w1 == 1, "R2 one-cycle skew counted", w1, 1);

    // R2 skew of two cycles rejected
    @(negedge clk); hit = 16'h0001;
    @(negedge clk); hit = '0;
    @(negedge clk); hit = 16'h0002;
    @(negedge clk); hit = '0;
    prev_high = 0;
    observe(30, first, w1, w2, np, cs);
    check(!cs, "R2 two-cycle skew no coinc", cs, 0);
    check(np == 0, "R2 two-cycle skew no pulse", np, 0);

    // R4 held level counts once
    win_len = 8'd20;
    @(negedge clk); hit = 16'h0003;
    repeat (5) @(negedge clk);
    hit = '0;
    prev_high = 0;
    observe(50, first, w1, w2, np, cs);
    check(w1 == 1, "R4 held level counts once", w1, 1);

    // R4 two separate hits on one bar count twice
    win_len = 8'd12;
    fire(16'h0003);
    repeat (3) @(negedge clk);
    fire(16'h0003);
    prev_high = 0;
    observe(50, first, w1, w2, np, cs);
    check(w1 == 2, "R4 repeated bar hits", w1, 2);

    // R7 saturation at 8
    win_len = 8'd60;
    repeat (10) begin
      fire(16'h0003);
      repeat (2) @(negedge clk);
    end
    prev_high = 0;
    observe(100, first, w1, w2, np, cs);
    check(w1 == 8, "R7 saturated width", w1, 8);

    // R8 hits during pulse held for next window
    win_len = 8'd2;
    fire(16'hFFFF);
    prev_high = 0;
    first = -1; w1 = 0; w2 = 0; np = 0;
    for (int i = 0; i < 60; i++) begin
      if (i == 9) hit = 16'h0003;
      if (i == 10) hit = '0;
      if (width_pulse) begin
        if (!prev_high) np++;
        if (np == 1) w1++; else w2++;
      end
      prev_high = width_pulse;
      @(negedge clk);
    end
    check(w1 == 8, "R8 first pulse", w1, 8);
    check(np == 2 && w2 == 1, "R8 held second pulse", w2, 1);

    // R9 disabled window
    win_len = 8'd0;
    fire(16'hFFFF);
    prev_high = 0;
    observe(30, first, w1, w2, np, cs);
    check(np == 0, "R9 no pulse when disabled", np, 0);
    win_len = 8'd3;
    fire(16'h0003);
    prev_high = 0;
    observe(30, first, w1, w2, np, cs);
    check(w1 == 1, "R9 stale count discarded", w1, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule